// File: doc/BRIEF.md
# Coarse-Fine Deskew Search Controller

This controller closes the loop around a programmable delay element. It writes delay codes to a safe updater, waits for each write to land and settle, and then reads a signed phase-error metric from a phase monitor. It searches for the code whose averaged error is closest to zero. The search runs in two passes. A coarse pass visits codes at a fixed stride across the whole range. A fine pass then visits every code in a programmable window centred on the best coarse code. The controller then confirms the winner with repeated stable measurements and enters a tracking loop that tries one code up and one code down.

Each visit to a code uses the same sequence. The controller issues a one-cycle request and waits for the updater's completion pulse. It lets a programmable number of clock cycles pass, so that the output can settle, and then collects a power-of-two number of metric reads. Their mean is the code's score. Their spread, the largest read minus the smallest, is the noise indicator. If the spread at any code is larger than the programmed limit, the controller stops with a fail flag and does not keep hunting.

States: IDLE (waits for start), ISSUE (request pulse), WAIT_UPD (waits for completion), SETTLE (settle countdown), MEASURE (collects reads), EVAL (noise check and best-code update), ADVANCE (picks the next code or phase), HALT (stopped after fail or fault). Transitions:
- IDLE→ISSUE on start.
- ISSUE→WAIT_UPD always.
- WAIT_UPD→SETTLE on update done.
- SETTLE→MEASURE when the countdown ends.
- MEASURE→EVAL when the read set is full.
- EVAL→HALT on excess spread, otherwise EVAL→ADVANCE.
- ADVANCE→ISSUE for a new code, ADVANCE→MEASURE for another confirmation read set, ADVANCE→HALT on confirmation timeout or tracking fault.
- HALT→ISSUE on start.

The internal phase register steps through the phases coarse → fine → confirm → track-step ↔ track-base.

Top module: `deskew_search_ctrl`

## Requirements
- R1: After reset, req_valid, done, fail and track_fault are all 0 and best_code is 0.
- R2: After start, the coarse pass requests codes 0, COARSE_STEP, 2·COARSE_STEP and so on, as long as the code does not exceed 2^CODE_W−1.
- R3: Every code is requested with a single-cycle req_valid. No further request is made until upd_done has been seen for the current one.
- R4: Metric reads that arrive during the settle_cycles clock cycles after upd_done are not used.
- R5: A code's score is the arithmetic mean (floor) of 2^NREADS_LOG consecutive accepted reads.
- R6: The best code is the visited code with the smallest absolute score. When two codes tie, the one visited first is kept.
- R7: The fine pass requests every code from best−fine_span to best+fine_span in ascending order, clamped to the range 0 to 2^CODE_W−1.
- R8: If a read set's spread (maximum minus minimum) is larger than var_limit, fail goes to 1, done stays 0, and no further request is made until a new start.
- R9: After the fine pass, the best code is requested once. done rises only after STABLE_N consecutive read sets whose means lie within var_limit of the best score.
- R10: If STABLE_N consecutive stable sets are not reached within CONFIRM_MAX read sets, fail goes to 1 and requests stop.
- R11: Tracking alternates between a step request (best+1 first, then best−1, and so on; at a range end the step goes the other way) and a request back to the best code, which re-measures the reference. A stepped code with a smaller absolute score becomes the best code.
- R12: A step up must raise the score above the reference, and a step down must lower it. Otherwise track_fault goes to 1, done goes to 0, and requests stop.
- R13: start is ignored while a search or tracking is in progress. It is accepted only in IDLE or HALT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new search |
| fine_span | input | CODE_W | Half-width of the fine window |
| settle_cycles | input | SETTLE_W | Cycles to ignore reads after upd_done |
| var_limit | input | METRIC_W | Allowed spread, and allowed confirmation deviation |
| metric | input | METRIC_W | Signed phase-error read |
| metric_valid | input | 1 | metric is valid this cycle |
| upd_done | input | 1 | Updater finished applying the requested code |
| req_code | output | CODE_W | Code requested from the updater |
| req_valid | output | 1 | One-cycle request strobe |
| best_code | output | CODE_W | Current best code |
| done | output | 1 | Converged and tracking |
| fail | output | 1 | Aborted for noise or confirmation timeout |
| track_fault | output | 1 | Tracking step moved the score the wrong way |

## Verification
The plant model gives a linear error curve, and a driver predicts the full sequence of requested codes, which a monitor compares request by request. A curve centred between two coarse points checks the tie rule and the fine-window edges, and later tracking adoptions make the best code move. A target at the top code checks clamping of the fine window and reversal of the tracking step. A negative slope triggers the direction fault. Large alternating jitter triggers the spread abort, and an offset applied only during confirmation triggers the timeout. Every settle window begins with out-of-range reads, so a controller that used them would abort.

// File: rtl/dsk_pkg.sv
`timescale 1ns/1ps
package dsk_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_ISSUE, S_WAIT_UPD, S_SETTLE, S_MEASURE, S_EVAL, S_ADVANCE, S_HALT
    } state_e;

    typedef enum logic [2:0] {
        PH_COARSE, PH_FINE, PH_CONFIRM, PH_TRK_STEP, PH_TRK_BASE
    } phase_e;
endpackage

// File: rtl/dsk_settle_timer.sv
`timescale 1ns/1ps
module dsk_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (load)               cnt_q <= load_val;
        else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dsk_read_avg.sv
`timescale 1ns/1ps
module dsk_read_avg #(
    parameter int W    = 16,
    parameter int NLOG = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_val,
    output logic                full,
    output logic signed [W-1:0] avg,
    output logic        [W:0]   spread
);
    localparam int N  = 1 << NLOG;
    localparam int SW = W + NLOG;
    localparam int CW = NLOG + 1;

    logic        [CW-1:0] cnt_q;
    logic signed [SW-1:0] sum_q;
    logic signed [SW-1:0] shifted;
    logic signed [W-1:0]  min_q, max_q;

    assign full = (cnt_q == CW'(N));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sum_q <= '0;
            min_q <= '0;
            max_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            sum_q <= '0;
        end else if (en && in_valid && !full) begin
            cnt_q <= cnt_q + 1'b1;
            sum_q <= sum_q + {{NLOG{in_val[W-1]}}, in_val};
            if (cnt_q == '0) begin
                min_q <= in_val;
                max_q <= in_val;
            end else begin
                if (in_val < min_q) min_q <= in_val;
                if (in_val > max_q) max_q <= in_val;
            end
        end
    end

    assign shifted = sum_q >>> NLOG;
    assign avg     = shifted[W-1:0];
    assign spread  = {max_q[W-1], max_q} - {min_q[W-1], min_q};

    p_count_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(N));
endmodule

// File: rtl/dsk_best_pick.sv
`timescale 1ns/1ps
module dsk_best_pick #(
    parameter int CODE_W = 6,
    parameter int W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  cand_en,
    input  logic [CODE_W-1:0]     cand_code,
    input  logic signed [W-1:0]   cand_avg,
    input  logic                  load_en,
    input  logic [CODE_W-1:0]     load_code,
    input  logic signed [W-1:0]   load_avg,
    output logic [CODE_W-1:0]     best_code,
    output logic signed [W-1:0]   best_avg
);
    logic has_q;

    function automatic logic [W:0] mag(input logic signed [W-1:0] v);
        logic signed [W:0] e;
        e = {v[W-1], v};
        return (e < 0) ? -e : e;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            has_q     <= 1'b0;
            best_code <= '0;
            best_avg  <= '0;
        end else if (clr) begin
            has_q     <= 1'b0;
            best_code <= '0;
            best_avg  <= '0;
        end else if (load_en) begin
            best_code <= load_code;
            best_avg  <= load_avg;
        end else if (cand_en && (!has_q || mag(cand_avg) < mag(best_avg))) begin
            has_q     <= 1'b1;
            best_code <= cand_code;
            best_avg  <= cand_avg;
        end
    end

    p_best_never_worse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_en && has_q && !clr && !load_en) |=> mag(best_avg) <= $past(mag(best_avg)));
endmodule

// File: rtl/deskew_search_ctrl.sv
`timescale 1ns/1ps
module deskew_search_ctrl #(
    parameter int CODE_W      = 6,
    parameter int METRIC_W    = 16,
    parameter int SETTLE_W    = 8,
    parameter int NREADS_LOG  = 2,
    parameter int COARSE_STEP = 8,
    parameter int STABLE_N    = 3,
    parameter int CONFIRM_MAX = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [CODE_W-1:0]          fine_span,
    input  logic [SETTLE_W-1:0]        settle_cycles,
    input  logic [METRIC_W-1:0]        var_limit,
    input  logic signed [METRIC_W-1:0] metric,
    input  logic                       metric_valid,
    input  logic                       upd_done,
    output logic [CODE_W-1:0]          req_code,
    output logic                       req_valid,
    output logic [CODE_W-1:0]          best_code,
    output logic                       done,
    output logic                       fail,
    output logic                       track_fault
);
    import dsk_pkg::*;

    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int CNT_MAX  = (CONFIRM_MAX > STABLE_N) ? CONFIRM_MAX : STABLE_N;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam logic [CODE_W:0]   CODE_MAX_X = CODE_MAX[CODE_W:0];
    localparam logic [CODE_W:0]   STEP_X     = COARSE_STEP[CODE_W:0];
    localparam logic [CNT_W-1:0]  STABLE_C   = STABLE_N[CNT_W-1:0];
    localparam logic [CNT_W-1:0]  CONFIRM_C  = CONFIRM_MAX[CNT_W-1:0];

    state_e state_q, state_n;
    phase_e phase_q;

    logic [CODE_W-1:0]          code_q, hi_q;
    logic                       dir_up_q;
    logic [CNT_W-1:0]           stable_q, grp_q;
    logic signed [METRIC_W-1:0] base_q;
    logic                       done_q, fail_q, fault_q;

    logic                       avg_full, avg_clr;
    logic signed [METRIC_W-1:0] avg_val;
    logic        [METRIC_W:0]   avg_spread;
    logic signed [METRIC_W-1:0] best_avg;
    logic                       settle_exp;

    logic                       start_ok, spread_bad;
    logic                       coarse_more, fine_more;
    logic                       conf_ok, conf_reached, conf_timeout;
    logic                       trk_dir_ok, trk_better;
    logic                       go_measure, go_halt;
    logic [CODE_W:0]            coarse_next, b_ext, s_ext, hi_sum;
    logic [CODE_W-1:0]          fine_lo, fine_hi;
    logic signed [METRIC_W:0]   dev;
    logic        [METRIC_W:0]   dev_abs, lim_ext;
    logic                       cand_en, load_en;

    function automatic logic [METRIC_W:0] mag(input logic signed [METRIC_W-1:0] v);
        logic signed [METRIC_W:0] e;
        e = {v[METRIC_W-1], v};
        return (e < 0) ? -e : e;
    endfunction

    function automatic logic [CODE_W-1:0] step_to(input logic [CODE_W-1:0] b, input logic up);
        if (up) return (b == CODE_MAX[CODE_W-1:0]) ? b - 1'b1 : b + 1'b1;
        else    return (b == '0) ? b + 1'b1 : b - 1'b1;
    endfunction

    dsk_settle_timer #(.W(SETTLE_W)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == S_WAIT_UPD && upd_done),
        .load_val (settle_cycles),
        .run      (state_q == S_SETTLE),
        .expired  (settle_exp)
    );

    dsk_read_avg #(.W(METRIC_W), .NLOG(NREADS_LOG)) u_avg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (avg_clr),
        .en       (state_q == S_MEASURE),
        .in_valid (metric_valid),
        .in_val   (metric),
        .full     (avg_full),
        .avg      (avg_val),
        .spread   (avg_spread)
    );

    dsk_best_pick #(.CODE_W(CODE_W), .W(METRIC_W)) u_best (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_ok),
        .cand_en   (cand_en),
        .cand_code (code_q),
        .cand_avg  (avg_val),
        .load_en   (load_en),
        .load_code (code_q),
        .load_avg  (avg_val),
        .best_code (best_code),
        .best_avg  (best_avg)
    );

    // Decision terms shared by next-state and datapath logic
    always_comb begin
        start_ok     = start && (state_q == S_IDLE || state_q == S_HALT);
        lim_ext      = {1'b0, var_limit};
        spread_bad   = avg_spread > lim_ext;
        coarse_next  = {1'b0, code_q} + STEP_X;
        coarse_more  = coarse_next <= CODE_MAX_X;
        b_ext        = {1'b0, best_code};
        s_ext        = {1'b0, fine_span};
        fine_lo      = (b_ext > s_ext) ? best_code - fine_span : '0;
        hi_sum       = b_ext + s_ext;
        fine_hi      = (hi_sum > CODE_MAX_X) ? CODE_MAX[CODE_W-1:0] : hi_sum[CODE_W-1:0];
        fine_more    = code_q < hi_q;
        dev          = {avg_val[METRIC_W-1], avg_val} - {best_avg[METRIC_W-1], best_avg};
        dev_abs      = (dev < 0) ? -dev : dev;
        conf_ok      = dev_abs <= lim_ext;
        conf_reached = conf_ok && (stable_q + 1'b1 == STABLE_C);
        conf_timeout = !conf_reached && (grp_q + 1'b1 == CONFIRM_C);
        trk_dir_ok   = (code_q > best_code) ? (avg_val > base_q) : (avg_val < base_q);
        trk_better   = mag(avg_val) < mag(base_q);
        go_measure   = (phase_q == PH_CONFIRM) && !conf_reached && !conf_timeout;
        go_halt      = ((phase_q == PH_CONFIRM) && conf_timeout)
                    || ((phase_q == PH_TRK_STEP) && !trk_dir_ok);
        avg_clr      = (state_q == S_SETTLE && settle_exp)
                    || (state_q == S_ADVANCE && go_measure);
        cand_en      = (state_q == S_EVAL) && !spread_bad
                    && (phase_q == PH_COARSE || phase_q == PH_FINE);
        load_en      = (state_q == S_ADVANCE) && (phase_q == PH_TRK_STEP)
                    && trk_dir_ok && trk_better;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_n = S_ISSUE;
            S_ISSUE:    state_n = S_WAIT_UPD;
            S_WAIT_UPD: if (upd_done) state_n = S_SETTLE;
            S_SETTLE:   if (settle_exp) state_n = S_MEASURE;
            S_MEASURE:  if (avg_full) state_n = S_EVAL;
            S_EVAL:     state_n = spread_bad ? S_HALT : S_ADVANCE;
            S_ADVANCE:  state_n = go_halt ? S_HALT : (go_measure ? S_MEASURE : S_ISSUE);
            S_HALT:     if (start) state_n = S_ISSUE;
            default:    state_n = S_IDLE;
        endcase
    end

    // Search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= PH_COARSE;
            code_q   <= '0;
            hi_q     <= '0;
            dir_up_q <= 1'b1;
            stable_q <= '0;
            grp_q    <= '0;
            base_q   <= '0;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
            fault_q  <= 1'b0;
        end else if (start_ok) begin
            phase_q  <= PH_COARSE;
            code_q   <= '0;
            dir_up_q <= 1'b1;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
            fault_q  <= 1'b0;
        end else if (state_q == S_EVAL && spread_bad) begin
            fail_q <= 1'b1;
            done_q <= 1'b0;
        end else if (state_q == S_ADVANCE) begin
            unique case (phase_q)
                PH_COARSE: begin
                    if (coarse_more) begin
                        code_q <= coarse_next[CODE_W-1:0];
                    end else begin
                        phase_q <= PH_FINE;
                        code_q  <= fine_lo;
                        hi_q    <= fine_hi;
                    end
                end
                PH_FINE: begin
                    if (fine_more) begin
                        code_q <= code_q + 1'b1;
                    end else begin
                        phase_q  <= PH_CONFIRM;
                        code_q   <= best_code;
                        stable_q <= '0;
                        grp_q    <= '0;
                    end
                end
                PH_CONFIRM: begin
                    grp_q    <= grp_q + 1'b1;
                    stable_q <= conf_ok ? stable_q + 1'b1 : '0;
                    if (conf_reached) begin
                        done_q  <= 1'b1;
                        base_q  <= avg_val;
                        phase_q <= PH_TRK_STEP;
                        code_q  <= step_to(best_code, dir_up_q);
                    end else if (conf_timeout) begin
                        fail_q <= 1'b1;
                    end
                end
                PH_TRK_STEP: begin
                    if (!trk_dir_ok) begin
                        fault_q <= 1'b1;
                        done_q  <= 1'b0;
                    end else begin
                        phase_q  <= PH_TRK_BASE;
                        code_q   <= trk_better ? code_q : best_code;
                        dir_up_q <= !dir_up_q;
                    end
                end
                PH_TRK_BASE: begin
                    base_q  <= avg_val;
                    phase_q <= PH_TRK_STEP;
                    code_q  <= step_to(best_code, dir_up_q);
                end
                default: phase_q <= PH_COARSE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_valid   = (state_q == S_ISSUE);
        req_code    = code_q;
        done        = done_q;
        fail        = fail_q;
        track_fault = fault_q;
    end

    p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);
    p_wait_blocks_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_UPD && !upd_done) |=> !req_valid);
    p_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && (fail || track_fault)));
    p_best_frozen_confirm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CONFIRM && $past(phase_q == PH_CONFIRM)) |-> $stable(best_code));
    p_track_unit_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && phase_q == PH_TRK_STEP)
            |-> (req_code == best_code + 1'b1 || req_code == best_code - 1'b1));
    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);
endmodule

// File: tb/deskew_search_ctrl_tb_top.sv
`timescale 1ns/1ps
module deskew_search_ctrl_tb_top;
    localparam int CODE_W = 6;
    localparam int CMAX   = (1 << CODE_W) - 1;
    localparam int STEP   = 8;
    localparam int MW     = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [CODE_W-1:0]    fine_span = '0;
    logic [7:0]           settle_cycles = 8'd8;
    logic [MW-1:0]        var_limit = 16'd20;
    logic signed [MW-1:0] metric = '0;
    logic                 metric_valid = 1'b0;
    logic                 upd_done = 1'b0;
    logic [CODE_W-1:0]    req_code, best_code;
    logic                 req_valid, done, fail, track_fault;

    deskew_search_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .fine_span(fine_span),
        .settle_cycles(settle_cycles), .var_limit(var_limit), .metric(metric),
        .metric_valid(metric_valid), .upd_done(upd_done), .req_code(req_code),
        .req_valid(req_valid), .best_code(best_code), .done(done), .fail(fail),
        .track_fault(track_fault)
    );

    int    n_checks = 0, n_fail = 0;
    int    exp_q[$];
    string tag_q[$];
    int    exp_best, exp_out, conf_idx, extra;
    int    pK, pT, pJ, pOff;
    int    conf_reads;
    bit    conf_cnt_on, done_prev;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int f(input int c);
        return pK * (c - pT);
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int step_to(input int b, input bit up);
        if (up) return (b == CMAX) ? b - 1 : b + 1;
        return (b == 0) ? b + 1 : b - 1;
    endfunction

    // Driver side: predict the request stream and the outcome from the requirements
    task automatic build(input int span, input bit jf, input int ntrk, input string xt);
        int bc, bv, n, lo, hi, base, t, v;
        bit up;
        exp_q.delete(); tag_q.delete();
        if (jf) begin
            exp_q.push_back(0); tag_q.push_back("R8");
            exp_out = 1; conf_idx = -1;
            return;
        end
        bc = 0; bv = 1 << 30; n = 0;
        for (int c = 0; c <= CMAX; c += STEP) begin
            exp_q.push_back(c); tag_q.push_back({"R2", xt}); n++;
            if (iabs(f(c)) < bv) begin bv = iabs(f(c)); bc = c; end
        end
        lo = (bc - span < 0) ? 0 : bc - span;
        hi = (bc + span > CMAX) ? CMAX : bc + span;
        for (int c = lo; c <= hi; c++) begin
            exp_q.push_back(c); tag_q.push_back("R7 R3"); n++;
            if (iabs(f(c)) < bv) begin bv = iabs(f(c)); bc = c; end
        end
        exp_q.push_back(bc); tag_q.push_back("R9");
        conf_idx = n + 1;
        exp_best = bc;
        if (pOff != 0) begin exp_out = 1; return; end
        exp_out = 0; base = f(bc); up = 1'b1;
        for (int i = 0; i < ntrk; i++) begin
            t = step_to(exp_best, up);
            exp_q.push_back(t); tag_q.push_back("R11");
            v = f(t);
            if (!((t > exp_best) ? (v > base) : (v < base))) begin
                exp_out = 2;
                return;
            end
            if (iabs(v) < iabs(base)) exp_best = t;
            exp_q.push_back(exp_best); tag_q.push_back("R11");
            base = f(exp_best); up = !up;
        end
    endtask

    // Plant: updater handshake plus phase monitor with settle garbage and jitter
    int pend, pend_code, applied, reqs, since;
    bit tog, js, conf_on;
    always @(negedge clk) begin
        if (!rst_n) begin
            upd_done = 0; metric_valid = 0; pend = 0; reqs = 0; since = 1000;
            tog = 0; js = 0; conf_on = 0; conf_cnt_on = 0; conf_reads = 0; applied = 0;
        end else begin
            upd_done = 0;
            if (req_valid) begin
                pend = 3; pend_code = int'(req_code); reqs++;
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    upd_done = 1; applied = pend_code; since = 0;
                    conf_on = (reqs == conf_idx);
                    if (reqs == conf_idx) begin conf_cnt_on = 1; conf_reads = 0; end
                end
            end
            if (since < 1000) since++;
            tog = !tog; metric_valid = tog;
            if (tog) begin
                if (conf_cnt_on) conf_reads++;
                if (since < int'(settle_cycles) - 1) metric = 16'sd5000;
                else begin
                    metric = MW'(f(applied) + (conf_on ? pOff : 0) + (js ? pJ : -pJ));
                    js = !js;
                end
            end
        end
    end

    // Monitor: pop expected requests as the design issues them
    always @(negedge clk) begin
        if (rst_n) begin
            if (req_valid) begin
                if (exp_q.size() > 0) begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(int'(req_code) == e, t, int'(req_code), e);
                end else extra++;
            end
            if (done && !done_prev)
                chk(conf_reads >= 12, "R9 stable reads before done", conf_reads, 12);
            done_prev = done;
        end else done_prev = 0;
    end

    task automatic run_case(input int K, input int T, input int J, input int off,
                            input int span, input bit jf, input int ntrk,
                            input bit mid_start, input string xt, input string otag);
        int guard;
        rst_n = 0; start = 0;
        pK = K; pT = T; pJ = J; pOff = off; fine_span = CODE_W'(span); extra = 0;
        build(span, jf, ntrk, xt);
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        if (mid_start) begin
            repeat (150) @(negedge clk);
            start = 1;
            @(negedge clk) start = 0;
        end
        guard = 0;
        while (exp_q.size() > 0 && guard < 30000) begin @(negedge clk); guard++; end
        chk(exp_q.size() == 0, {otag, " all requests seen"}, exp_q.size(), 0);
        repeat (exp_out == 0 ? 5 : 300) @(negedge clk);
        chk(done == (exp_out == 0), {otag, " done"}, done, exp_out == 0);
        chk(fail == (exp_out == 1), {otag, " fail"}, fail, exp_out == 1);
        chk(track_fault == (exp_out == 2), {otag, " track_fault"}, track_fault, exp_out == 2);
        if (exp_out != 1)
            chk(int'(best_code) == exp_best, {otag, " best_code"}, int'(best_code), exp_best);
        if (exp_out != 0)
            chk(extra == 0, {otag, " no request after stop"}, extra, 0);
    endtask

    initial begin
        pK = 4; pT = 0; pJ = 3; pOff = 0; conf_idx = -1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_valid == 0, "R1 req_valid", req_valid, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(fail == 0, "R1 fail", fail, 0);
        chk(track_fault == 0, "R1 track_fault", track_fault, 0);
        chk(best_code == 0, "R1 best_code", best_code, 0);
        // Centred between coarse points; mid-run start must be ignored; settle garbage every code
        run_case(4, 20, 3, 0, 4, 0, 2, 1, " R13", "R4 R6");
        // Tie between coarse 0 and 8, narrow window, tracking adopts better codes
        run_case(4, 4, 3, 0, 2, 0, 4, 0, "", "R5 R6 R11");
        // Target at top code: clamped window, reversed step at the range end
        run_case(4, 63, 3, 0, 10, 0, 2, 0, "", "R7 R11");
        // Noisy reads abort
        run_case(4, 20, 50, 0, 4, 1, 0, 0, "", "R8");
        // Wrong slope: tracking direction fault
        run_case(-4, 20, 3, 0, 4, 0, 2, 0, "", "R12");
        // Confirmation reads drift away: timeout
        run_case(4, 20, 3, 100, 4, 0, 0, 0, "", "R10");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule